// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell software why the chip last came out of reset. Four one-cycle event inputs report a power-on reset, a brown-out reset, an external pin reset and a watchdog reset. Each event sets its own flag. A power-on event also wipes the three other flags, so after power-up only the power-on flag remains.

Software sees the flags as the low nibble of one 8-bit register on a simple register bus. It reads them, then writes zeros to the flags it has handled. Writing a one leaves a flag as it was, so software cannot invent a reset cause. The upper nibble is reserved and reads as zero.

The flag storage has no reset of its own. The system bus reset does not touch it. Only the power-on event brings it to a known value, so the flags survive every reset except power-on.

Top module: `reset_cause_reg`

## Requirements
- R1: Read data bits 7 to 4 are always zero, and write data bits 7 to 4 have no effect on any flag.
- R2: A watchdog event (wdtEvt) sets flag bit 3 on the next clock edge.
- R3: A brown-out event (borEvt) sets flag bit 2 on the next clock edge.
- R4: An external-pin event (extEvt) sets flag bit 1 on the next clock edge.
- R5: A power-on event (porEvt) sets flag bit 0 on the next clock edge and clears flag bits 3 to 1, except bits whose own event is asserted in the same cycle.
- R6: A write to the register address with data bit k equal to 0 clears flag k (k = 0 to 3). A write with data bit k equal to 1 leaves flag k unchanged. Flag bit 0 can be cleared only by such a write.
- R7: When a reset event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: With no event and no write to the register address, every flag holds its value. This includes cycles where sysRstN is low.
- R9: Only address REG_ADDR (default 0x54) reaches the register. Reads at any other address return zero, and writes there change nothing. Reads are combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Active-low system reset; does not initialise the flags |
| porEvt | input | 1 | One-cycle power-on reset event |
| borEvt | input | 1 | One-cycle brown-out reset event |
| extEvt | input | 1 | One-cycle external pin reset event |
| wdtEvt | input | 1 | One-cycle watchdog reset event |
| busAddr | input | ADDR_W (8) | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W (8) | Write data |
| busRdData | output | DATA_W (8) | Combinational read data |

## Verification
The bench uses the default parameters: an 8-bit address with the register at 0x54 and an 8-bit data word. With these values the whole behaviour becomes small enough to sweep completely. The sweep covers every 4-bit starting flag state, every combination of the four events, every low write nibble, and writes both at the register address and away from it. This reaches every same-cycle conflict between a power-on wipe, a set and a clear. Separate sequences drop sysRstN while flags are held, and they write ones to the reserved bits.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int FLAG_W = 4;
  localparam int IDX_POR = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_BOR = 2;
  localparam int IDX_WDT = 3;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              porWipe;
  } flagCmd_t;
endpackage

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h54
) (
  input  logic              porEvt,
  input  logic              borEvt,
  input  logic              extEvt,
  input  logic              wdtEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output flagCmd_t          cmd,
  output logic              addrHit
);
  logic writeHit;

  always_comb begin
    addrHit  = (busAddr == REG_ADDR);
    writeHit = busWrEn && addrHit;

    cmd.setMask          = '0;
    cmd.setMask[IDX_POR] = porEvt;
    cmd.setMask[IDX_EXT] = extEvt;
    cmd.setMask[IDX_BOR] = borEvt;
    cmd.setMask[IDX_WDT] = wdtEvt;

    // Zero-written bits clear; one-written bits are left alone.
    cmd.clrMask = writeHit ? ~busWrData[FLAG_W-1:0] : '0;
    cmd.porWipe = porEvt;
  end
endmodule

// File: rtl/rstcause_dp.sv
module rstcause_dp
  import rstcause_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  flagCmd_t          cmd,
  input  logic              addrHit,
  output logic [FLAG_W-1:0] flagState,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [FLAG_W-1:0] WIPE_MASK = {{(FLAG_W-1){1'b1}}, 1'b0};

  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] keepMask;
  logic [FLAG_W-1:0] flagNext;

  always_comb begin
    keepMask = ~cmd.clrMask & ~(cmd.porWipe ? WIPE_MASK : '0);
    // Sets are applied last, so an event always beats a clear.
    flagNext = (flagQ & keepMask) | cmd.setMask;
  end

  // Kept out of every reset domain; only the power-on event defines it.
  always_ff @(posedge clk) begin
    flagQ <= flagNext;
  end

  generate
    if (DATA_W > FLAG_W) begin : gWide
      assign rdData = addrHit ? {{(DATA_W-FLAG_W){1'b0}}, flagQ} : '0;
    end else begin : gNarrow
      assign rdData = addrHit ? flagQ[DATA_W-1:0] : '0;
    end
  endgenerate

  assign flagState = flagQ;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h54
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              porEvt,
  input  logic              borEvt,
  input  logic              extEvt,
  input  logic              wdtEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  flagCmd_t          cmd;
  logic              addrHit;
  logic [FLAG_W-1:0] flagState;
  logic              unusedRst;

  assign unusedRst = sysRstN;

  rstcause_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) uCtrl (
    .porEvt(porEvt), .borEvt(borEvt), .extEvt(extEvt), .wdtEvt(wdtEvt),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .cmd(cmd), .addrHit(addrHit)
  );

  rstcause_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .cmd(cmd), .addrHit(addrHit),
    .flagState(flagState), .rdData(busRdData)
  );
endmodule

// File: rtl/reset_cause_reg_chk.sv
module reset_cause_reg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h54
) (
  input logic              clk,
  input logic              sysRstN,
  input logic              porEvt,
  input logic              borEvt,
  input logic              extEvt,
  input logic              wdtEvt,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [3:0]        flagState
);
  logic anyEvt;
  logic regWrite;
  assign anyEvt   = porEvt | borEvt | extEvt | wdtEvt;
  assign regWrite = busWrEn && (busAddr == REG_ADDR);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!sysRstN)
    busRdData[DATA_W-1:4] == '0);
  assert_wdt_sets_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    wdtEvt |=> flagState[3]);
  assert_bor_sets_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    borEvt |=> flagState[2]);
  assert_ext_sets_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    extEvt |=> flagState[1]);
  assert_por_wipes_R5: assert property (@(posedge clk) disable iff (!sysRstN)
    (porEvt && !borEvt && !extEvt && !wdtEvt) |=> flagState == 4'b0001);
  assert_ones_keep_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    (regWrite && busWrData[3:0] == 4'hF && !anyEvt) |=> $stable(flagState));
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    (regWrite && busWrData[3:0] == 4'h0 && porEvt) |=> flagState[0]);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!sysRstN)
    (!anyEvt && !regWrite) |=> $stable(flagState));
  assert_decode_R9: assert property (@(posedge clk) disable iff (!sysRstN)
    (busAddr != REG_ADDR) |-> busRdData == '0);
endmodule

bind reset_cause_reg reset_cause_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) uChk (
  .clk(clk), .sysRstN(sysRstN), .porEvt(porEvt), .borEvt(borEvt),
  .extEvt(extEvt), .wdtEvt(wdtEvt), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .flagState(flagState)
);

// File: tb/reset_cause_reg_test.sv
`timescale 1ns/1ps
module reset_cause_reg_test;
  localparam logic [7:0] REG = 8'h54;
  localparam logic [7:0] OFF = 8'h34;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic porEvt = 0, borEvt = 0, extEvt = 0, wdtEvt = 0;
  logic [7:0] busAddr = REG;
  logic       busWrEn = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [3:0] expFlags = 4'h0;

  always #5 clk = ~clk;

  reset_cause_reg uut (
    .clk(clk), .sysRstN(sysRstN), .porEvt(porEvt), .borEvt(borEvt),
    .extEvt(extEvt), .wdtEvt(wdtEvt), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: read 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One bus/event cycle, then a read-back of the register.
  task automatic step(input logic [3:0] ev, input logic wr, input logic [7:0] addr,
                      input logic [7:0] data, input string req);
    logic [3:0] clr;
    @(negedge clk);
    porEvt = ev[0]; extEvt = ev[1]; borEvt = ev[2]; wdtEvt = ev[3];
    busWrEn = wr; busAddr = addr; busWrData = data;
    #1;
    if (addr != REG) check("R9", busRdData, 8'h00);
    clr = (wr && addr == REG) ? ~data[3:0] : 4'h0;
    expFlags = (expFlags & ~clr & ~(ev[0] ? 4'hE : 4'h0)) | ev;
    @(posedge clk);
    #2;
    porEvt = 0; extEvt = 0; borEvt = 0; wdtEvt = 0;
    busWrEn = 0; busAddr = REG; busWrData = 8'h00;
    #1;
    check(req, busRdData, {4'h0, expFlags});
  endtask

  function automatic string tagFor(input logic [3:0] ev, input logic wr,
                                   input logic [7:0] addr, input logic [7:0] data);
    logic [3:0] clr;
    clr = (wr && addr == REG) ? ~data[3:0] : 4'h0;
    if ((ev & clr) != 0) return "R7";
    if (ev[0]) return "R5";
    if (ev[3]) return "R2";
    if (ev[2]) return "R3";
    if (ev[1]) return "R4";
    if (wr && addr == REG) return "R6";
    if (addr != REG) return "R9";
    return "R8";
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        testsRun++; testsFailed++;
        $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    // Power-on during system reset defines the flags (R5).
    step(4'b0001, 1'b0, REG, 8'h00, "R5");
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
    check("R5", busRdData, 8'h01);

    // Directed: each event sets its own flag.
    step(4'b1000, 1'b0, REG, 8'h00, "R2");
    step(4'b0100, 1'b0, REG, 8'h00, "R3");
    step(4'b0010, 1'b0, REG, 8'h00, "R4");
    // Reserved bits: writing ones there plus ones everywhere changes nothing (R1).
    step(4'b0000, 1'b1, REG, 8'hFF, "R1");
    step(4'b0000, 1'b1, REG, 8'hF0, "R6");
    // System reset leaves flags alone (R8).
    step(4'b1010, 1'b0, REG, 8'h00, "R2");
    @(negedge clk); sysRstN = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R8", busRdData, {4'h0, expFlags});
    sysRstN = 1'b1;
    // Off-address write does nothing (R9).
    step(4'b0000, 1'b1, OFF, 8'h00, "R9");
    // Power-on wipes others (R5).
    step(4'b0001, 1'b0, REG, 8'h00, "R5");

    // Exhaustive sweep: start state x events x write nibble x address hit.
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int w = 0; w < 32; w++) begin
          logic [7:0] addr;
          logic [7:0] data;
          addr = w[4] ? REG : OFF;
          data = {4'hA, w[3:0]};
          step(4'(s) | 4'b0001, 1'b0, REG, 8'h00, "R5");
          if (s[0] == 1'b0) step(4'b0000, 1'b1, REG, 8'hFE, "R6");
          step(4'(e), 1'b1, addr, data, tagFor(4'(e), 1'b1, addr, data));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule